// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and a 16-bit asynchronous static RAM that has separate active-low chip enables for its upper and lower bytes. The host offers one request at a time over a valid/ready handshake. Each request carries a read/write flag, a word address, write data and a 2-bit byte mask. The controller turns every accepted request into a timed sequence on the memory pins. First it drives the address while all strobes are high. Then it asserts the chip enables for the selected bytes together with either the write strobe or the output enable. Next it releases every strobe on one clock edge while the address stays put. Finally it waits out a recovery gap before it accepts the next request.

The write pulse width, the read access wait and the recovery gap are parameters counted in clock cycles. Choose them so that they cover the memory's datasheet figures at the chosen clock. Read data is sampled on the clock edge that ends the access wait. It comes back as a one-cycle response pulse, and the byte lanes that were not selected read as zero. The write-data drivers are enabled only while the write strobe is low.

Top module: `sram_seq_ctrl`

## Requirements
- R1: During and right after reset: `req_ready` is 1, `rsp_valid` is 0, `mem_dq_oe` is 0, and `mem_we_n`, `mem_oe_n`, `mem_ceu_n` and `mem_cel_n` are all 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. After that edge `req_ready` stays 0 for exactly 2 + P + REC_CYC cycles. P is WR_CYC for a write and ACC_CYC for a read.
- R3: `mem_addr` takes the request's address in the cycle after acceptance, while all strobes are still high. It stays unchanged for every cycle in which any strobe is low and for the cycle in which the strobes are released.
- R4: Mask bit 1 selects the upper byte (data bits 15:8) through `mem_ceu_n`. Mask bit 0 selects the lower byte (bits 7:0) through `mem_cel_n`. Mask 2'b11 asserts both. While a strobe phase is active the chip enables are low exactly for the set mask bits. Mask 2'b00 lowers no strobe at all and leaves memory contents unchanged.
- R5: A write holds `mem_we_n` low for exactly WR_CYC consecutive cycles, and `mem_oe_n` is 1 in all of them. `mem_we_n` and both chip enables return high on the same clock edge.
- R6: `mem_dq_oe` is 1 exactly in the cycles where `mem_we_n` is 0. In those cycles `mem_dq_out` carries the request's full write data.
- R7: A read holds `mem_oe_n` low for exactly ACC_CYC cycles and samples `mem_dq_in` on the edge that ends the last of them. `rsp_valid` is then 1 for one cycle. `rsp_rdata` holds the sampled bytes for set mask bits and zero for clear mask bits. A read with mask 2'b00 still returns a response, with data 0.
- R8: Between the release of one strobe phase and the start of the next there are at least REC_CYC + 3 cycles with all strobes high.
- R9: A request held valid while the controller is busy is taken exactly once, on the first cycle `req_ready` is 1 again. Requests are served in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 2*BYTE_W | Write data |
| req_bmask | input | 2 | Byte select: bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 2*BYTE_W | Read data, unselected lanes zero |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | 2*BYTE_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 2*BYTE_W | Data returned by memory |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ceu_n | output | 1 | Active-low upper byte chip enable |
| mem_cel_n | output | 1 | Active-low lower byte chip enable |

## Verification
The assertions check these pin relations on every cycle:
- the output enable stays high while the write strobe is low;
- the data drivers follow the write strobe;
- the address holds across each strobe phase and its release cycle;
- the chip enables match the mask and never move without a strobe;
- the write strobe and chip enables release together;
- the recovery gap is honoured;
- the read response lasts a single cycle.

Only the bench scenarios can show the rest. A memory model that returns valid data only after the access wait exposes a sample taken too early. Byte-masked writes followed by full reads prove that the unselected bytes stay untouched. Stalled back-to-back requests confirm that none is lost or duplicated.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RECOVER
  } seq_state_e;
endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int WR_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       op_wr,
  output logic       cap_en,
  output seq_state_e st_d
);
  localparam int MAX_AW  = (ACC_CYC > WR_CYC) ? ACC_CYC : WR_CYC;
  localparam int MAX_CYC = (MAX_AW > REC_CYC) ? MAX_AW : REC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_zero;
  logic              op_wr_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign cnt_zero  = (cnt_q == '0);
  assign cap_en    = (st_q == ST_STROBE) & cnt_zero & ~op_wr_q;
  assign op_wr     = op_wr_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE:    if (accept) st_d = ST_SETUP;
      ST_SETUP: begin
        st_d  = ST_STROBE;
        cnt_d = op_wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(ACC_CYC - 1);
      end
      ST_STROBE: begin
        if (cnt_zero) st_d = ST_HOLD;
        else          cnt_d = cnt_q - 1'b1;
      end
      ST_HOLD: begin
        st_d  = ST_RECOVER;
        cnt_d = CNT_W'(REC_CYC - 1);
      end
      ST_RECOVER: begin
        if (cnt_zero) st_d = ST_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      op_wr_q <= 1'b0;
    else if (accept) op_wr_q <= req_write;
  end

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> !cap_en);
endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      accept,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [BYTE_W*LANES-1:0]   req_wdata,
  input  logic [LANES-1:0]          req_mask,
  input  logic                      op_wr,
  input  seq_state_e                st_d,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [BYTE_W*LANES-1:0]   mem_dq_out,
  output logic                      mem_dq_oe,
  output logic                      mem_we_n,
  output logic                      mem_oe_n,
  output logic [LANES-1:0]          mem_ce_n,
  output logic [LANES-1:0]          op_mask
);
  localparam int DATA_W = BYTE_W * LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              strobe_nxt, any_lane;
  logic              we_n_q, oe_n_q, dq_oe_q;
  logic [LANES-1:0]  ce_n_q;
  logic              any_strobe;

  assign strobe_nxt = (st_d == ST_STROBE);
  assign any_lane   = |mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      we_n_q  <= ~(strobe_nxt & op_wr & any_lane);
      oe_n_q  <= ~(strobe_nxt & ~op_wr & any_lane);
      dq_oe_q <= strobe_nxt & op_wr & any_lane;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane_ce
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_n_q[i] <= 1'b1;
      else        ce_n_q[i] <= ~(strobe_nxt & mask_q[i]);
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_ce_n   = ce_n_q;
  assign op_mask    = mask_q;
  assign any_strobe = ~we_n_q | ~oe_n_q | ~(&ce_n_q);

  // R5
  oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R5
  joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (&mem_ce_n));

  // R6
  driver_follows_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_we_n);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe || $past(any_strobe)) |-> $stable(mem_addr));

  // R4
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !(&mem_ce_n));

  // R4
  ce_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_ce_n) |-> (mem_ce_n == ~mask_q));
endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [LANES-1:0]        op_mask,
  input  logic [BYTE_W*LANES-1:0] mem_dq_in,
  output logic                    rsp_valid,
  output logic [BYTE_W*LANES-1:0] rsp_rdata
);
  logic [BYTE_W*LANES-1:0] rdata_q;
  logic                    valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= cap_en;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rdata_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (cap_en)
        rdata_q[i*BYTE_W +: BYTE_W] <= op_mask[i] ? mem_dq_in[i*BYTE_W +: BYTE_W] : '0;
    end

    // R7
    masked_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !op_mask[i]) |-> (rsp_rdata[i*BYTE_W +: BYTE_W] == '0));
  end

  assign rsp_valid = valid_q;
  assign rsp_rdata = rdata_q;

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BYTE_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int WR_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*BYTE_W-1:0]   req_wdata,
  input  logic [1:0]            req_bmask,
  output logic                  rsp_valid,
  output logic [2*BYTE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*BYTE_W-1:0]   mem_dq_out,
  output logic                  mem_dq_oe,
  input  logic [2*BYTE_W-1:0]   mem_dq_in,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_ceu_n,
  output logic                  mem_cel_n
);
  localparam int LANES   = 2;
  localparam int GAP_MIN = REC_CYC + 3;
  localparam int GAP_W   = $clog2(GAP_MIN + 1);

  logic       accept, op_wr, cap_en;
  seq_state_e st_d;
  logic [LANES-1:0] ce_n, op_mask;

  sram_seq_fsm #(
    .ACC_CYC(ACC_CYC), .WR_CYC(WR_CYC), .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .op_wr(op_wr), .cap_en(cap_en),
    .st_d(st_d)
  );

  sram_seq_pins #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .LANES(LANES)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_bmask), .op_wr(op_wr), .st_d(st_d),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_ce_n(ce_n),
    .op_mask(op_mask)
  );

  sram_seq_rdcap #(
    .BYTE_W(BYTE_W), .LANES(LANES)
  ) u_rdcap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .op_mask(op_mask),
    .mem_dq_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_ceu_n = ce_n[1];
  assign mem_cel_n = ce_n[0];

  // Recovery-gap observer: counts cycles with every strobe high, saturating.
  logic             strobe_on, strobe_prev_q;
  logic [GAP_W-1:0] gap_q;

  assign strobe_on = ~mem_we_n | ~mem_oe_n | ~mem_ceu_n | ~mem_cel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q         <= GAP_W'(GAP_MIN);
      strobe_prev_q <= 1'b0;
    end else begin
      strobe_prev_q <= strobe_on;
      if (strobe_on)                       gap_q <= '0;
      else if (gap_q != GAP_W'(GAP_MIN))   gap_q <= gap_q + 1'b1;
    end
  end

  // R8
  recovery_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !strobe_prev_q) |-> (gap_q >= GAP_W'(GAP_MIN)));

  // R2
  busy_during_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> !req_ready);
endmodule

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W  = 17;
  localparam int ACC     = 3;
  localparam int WRC     = 2;
  localparam int REC     = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic [15:0] mem_dq_out, mem_dq_in;
  logic        mem_dq_oe, mem_we_n, mem_oe_n, mem_ceu_n, mem_cel_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(8), .ACC_CYC(ACC), .WR_CYC(WRC), .REC_CYC(REC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ceu_n(mem_ceu_n), .mem_cel_n(mem_cel_n)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  // Memory model: data valid only after ACC-1 edges of output enable low.
  logic [15:0] model_mem [int];
  int oe_cnt = 0;

  always @(posedge clk) begin : model_wr
    int a;
    logic [15:0] w;
    if (!mem_oe_n) oe_cnt <= oe_cnt + 1; else oe_cnt <= 0;
    if (!mem_we_n) begin
      a = int'(mem_addr);
      w = model_mem.exists(a) ? model_mem[a] : init_word(a);
      if (!mem_ceu_n) w[15:8] = mem_dq_out[15:8];
      if (!mem_cel_n) w[7:0]  = mem_dq_out[7:0];
      model_mem[a] = w;
    end
  end

  always @(negedge clk) begin : model_rd
    int a;
    a = int'(mem_addr);
    if (!mem_oe_n && oe_cnt >= ACC - 1)
      mem_dq_in = model_mem.exists(a) ? model_mem[a] : init_word(a);
    else
      mem_dq_in = 16'hBAD0;
  end

  // Scoreboard state written by the driver.
  logic [15:0] shadow [int];
  logic [15:0] exp_q [$];
  logic [16:0] exp_addr;
  logic [15:0] exp_wdata;
  logic [1:0]  exp_mask;
  int exp_busy = 0, issued = 0, accepts = 0, strobe_cycles = 0;

  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    logic [15:0] cur;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    issued++;
    exp_addr = a; exp_wdata = d; exp_mask = m;
    exp_busy = 2 + (wr ? WRC : ACC) + REC;
    cur = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(int'(a));
    if (wr) begin
      if (m[1]) cur[15:8] = d[15:8];
      if (m[0]) cur[7:0]  = d[7:0];
      shadow[int'(a)] = cur;
    end else begin
      exp_q.push_back({m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00});
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Pin monitor.
  int we_run = 0, oe_run = 0, busy_run = 0;
  bit prev_strobe = 1'b0;
  always @(negedge clk) begin
    bit s;
    if (rst_n && !done) begin
      s = !mem_we_n || !mem_oe_n || !mem_ceu_n || !mem_cel_n;
      if (req_valid && req_ready) accepts++;
      if (s) strobe_cycles++;
      chk(mem_dq_oe == !mem_we_n, "R6", "driver enable vs we_n", mem_dq_oe, !mem_we_n);
      if (!mem_we_n) begin
        we_run++;
        chk(mem_oe_n == 1'b1, "R5", "oe_n during write", mem_oe_n, 1);
        chk(mem_dq_out == exp_wdata, "R6", "write data on pins", mem_dq_out, exp_wdata);
      end else if (we_run > 0) begin
        chk(we_run == WRC, "R5", "write pulse width", we_run, WRC);
        chk(mem_ceu_n && mem_cel_n, "R5", "ce released with we", {mem_ceu_n, mem_cel_n}, 2'b11);
        we_run = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        chk(oe_run == ACC, "R7", "read strobe width", oe_run, ACC);
        oe_run = 0;
      end
      if (s || prev_strobe)
        chk(mem_addr == exp_addr, "R3", "address held", mem_addr, exp_addr);
      if (s)
        chk({mem_ceu_n, mem_cel_n} == ~exp_mask, "R4", "chip enables vs mask",
            {mem_ceu_n, mem_cel_n}, ~exp_mask);
      prev_strobe = s;
      if (!req_ready) busy_run++;
      else if (busy_run > 0) begin
        chk(busy_run == exp_busy, "R2", "busy length (R8 recovery)", busy_run, exp_busy);
        busy_run = 0;
      end
    end
  end

  // Response monitor.
  always @(negedge clk) begin
    logic [15:0] e;
    if (rst_n && !done && rsp_valid) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R7", "unexpected response", rsp_rdata, 0);
      else begin
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R7", "read data", rsp_rdata, e);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_bmask = '0;
    exp_addr = '0; exp_wdata = '0; exp_mask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_dq_oe, "R1", "ready/rsp/oe in reset",
        {req_ready, rsp_valid, mem_dq_oe}, 3'b100);
    chk({mem_we_n, mem_oe_n, mem_ceu_n, mem_cel_n} == 4'hF, "R1", "strobes in reset",
        {mem_we_n, mem_oe_n, mem_ceu_n, mem_cel_n}, 4'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk({req_ready, mem_we_n, mem_oe_n, mem_ceu_n, mem_cel_n} == 5'h1F, "R1",
        "after reset release", {req_ready, mem_we_n, mem_oe_n, mem_ceu_n, mem_cel_n}, 5'h1F);

    // R5 R6 full word write then R7 full read
    issue(1'b1, 17'h00010, 16'hC0DE, 2'b11);
    issue(1'b0, 17'h00010, 16'h0000, 2'b11);
    // R4 upper-only write, lower byte untouched
    issue(1'b1, 17'h00020, 16'hAB12, 2'b10);
    issue(1'b0, 17'h00020, 16'h0000, 2'b11);
    // R4 lower-only write
    issue(1'b1, 17'h00030, 16'h34CD, 2'b01);
    issue(1'b0, 17'h00030, 16'h0000, 2'b11);
    // R7 upper-only read, lower lane zero
    issue(1'b0, 17'h00010, 16'h0000, 2'b10);
    issue(1'b0, 17'h00030, 16'h0000, 2'b01);
    wait_idle();

    // R4 mask 00 write: no strobe, no change
    strobe_cycles = 0;
    issue(1'b1, 17'h00010, 16'hFFFF, 2'b00);
    wait_idle();
    chk(strobe_cycles == 0, "R4", "strobes for empty mask write", strobe_cycles, 0);
    issue(1'b0, 17'h00010, 16'h0000, 2'b11);
    // R7 mask 00 read returns zero without strobes
    wait_idle();
    strobe_cycles = 0;
    issue(1'b0, 17'h00040, 16'h0000, 2'b00);
    wait_idle();
    chk(strobe_cycles == 0, "R4", "strobes for empty mask read", strobe_cycles, 0);

    // R3 address boundaries
    issue(1'b1, 17'h1FFFF, 16'h8001, 2'b11);
    issue(1'b1, 17'h00000, 16'h7FFE, 2'b11);
    issue(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
    issue(1'b0, 17'h00000, 16'h0000, 2'b11);

    // R9 back-to-back mixed traffic held valid while busy
    for (int i = 0; i < 12; i++)
      issue(i[0], 17'h00100 + 17'(i >> 1), 16'h1111 * 16'(i + 1), 2'(i % 4));
    for (int i = 0; i < 6; i++)
      issue(1'b0, 17'h00100 + 17'(i), 16'h0000, 2'b11);
    wait_idle();
    repeat (4) @(negedge clk);

    chk(accepts == issued, "R9", "accepted request count", accepts, issued);
    chk(exp_q.size() == 0, "R9", "responses outstanding", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule